// File: doc/BRIEF.md
# Rate-Trimmed Hardware Time Counter

This block keeps a free-running 64-bit time count for precision time keeping. Each count stands for 8 ns of time. Software can trim the counter's frequency through a 32-bit rate word, an unsigned fixed-point multiplier in which 0x80000000 means exactly one count per clock cycle. Larger words make the counter run faster and smaller words make it run slower, in proportion. The intended trim range is roughly 0.968x to 1.032x of nominal, but any word is accepted. A 31-bit fractional accumulator carries the fractional part of the rate from one cycle to the next, so a trimmed rate stays exact over time.

A single clock-value register does two jobs. A persistent mode bit in the command word decides whether a write to it loads the counter or adds a signed offset to it. The command word also carries a one-shot clear of the counter and a persistent timestamp-correction enable. The correction enable comes out of reset set. A command write takes effect only when its valid flag is set. A read request captures the whole 64-bit count in one cycle, and the captured value is held on the read port.

Top module: `ptp_trim_clock`

## Requirements
- R1: Reset is synchronous and active high. While it is held and on the first cycle after it, the count and the read port are zero, the correction enable is 1, the mode is load, and the rate word is 0x80000000.
- R2: With the rate word at 0x80000000 and no write pending, the count rises by exactly one on every clock edge.
- R3: For any rate word R, a 31-bit fraction f accumulates R each cycle. The count rises by the integer part of (f + R) / 2^31, which is 0, 1 or 2, and f keeps the remainder.
- R4: A rate write is captured on the edge where its strobe is high. That edge still uses the old rate, and the new rate applies from the next edge on.
- R5: A command write whose bit 31 is 0 has no effect on the mode, the correction enable or the count, including when its clear bit is set.
- R6: Command bit 0 selects the mode (0 = load, 1 = add) and persists. A clock-value write uses the mode that was in force before the edge on which the write is captured.
- R7: In load mode, a clock-value write captured on edge E leaves the count advancing normally at E. At E+1 the count equals the written value and the fraction is cleared. Counting resumes from that value.
- R8: In add mode, a clock-value write captured on edge E changes the count at E+1 to the old count plus that edge's normal increment plus the written value, taken as a two's-complement offset. The fraction keeps running.
- R9: A valid command with bit 2 set, captured on edge E, makes the count zero at E+1 and clears the fraction.
- R10: Command bit 1 of a valid command write sets the correction-enable output from the next edge on.
- R11: A read request on edge E captures the count as it stood before E onto the read port. The read port holds that value until the next request.
- R12: If a clear and a clock-value write are captured on the same edge, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_wr | input | 1 | Rate word write strobe |
| rate_wdata | input | 32 | Rate word, 0x80000000 = nominal |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command: bit 31 valid, bit 2 clear, bit 1 correction enable, bit 0 add mode |
| val_wr | input | 1 | Clock-value write strobe |
| val_wdata | input | 64 | Clock value to load, or signed offset to add |
| rd_req | input | 1 | Read request, captures the count |
| rd_data | output | 64 | Captured count |
| time_o | output | 64 | Live count |
| corr_en_o | output | 1 | Timestamp-correction enable |

## Verification
The bench goes after the one-cycle lag of clock-value writes. A design that applied them on the strobe edge, or that dropped or doubled the tick on the apply edge, would be off by one count in the load and add checks. It also drives a fractional rate of 1.5x from a known zero fraction. A design with the carry taken from the wrong bit would advance twice as fast or half as fast, and one that reset the fraction every cycle would lose the half counts. The directed tests cover several conflicts: a mode change captured together with a value write, a clear captured together with a value write, and a command with the valid flag off. Each of these exposes a wrong priority or a missing valid gate as a wrong count or a flipped enable. Long random runs with rates near nominal compare the live count and the read port against a cycle model after every edge.

// File: rtl/ptp_tc_pkg.sv
package ptp_tc_pkg;

    localparam int CMD_W         = 32;
    localparam int CMD_VALID_BIT = 31;
    localparam int CMD_CLR_BIT   = 2;
    localparam int CMD_CORR_BIT  = 1;
    localparam int CMD_ADD_BIT   = 0;

    // What the counter does on the next edge
    typedef enum logic [1:0] {
        UPD_RUN   = 2'd0,
        UPD_LOAD  = 2'd1,
        UPD_STEP  = 2'd2,
        UPD_CLEAR = 2'd3
    } upd_kind_e;

    typedef struct packed {
        logic valid;
        logic add_mode;
        logic corr_en;
        logic clr;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic [CMD_W-1:0] w);
        cmd_t c;
        c.valid    = w[CMD_VALID_BIT];
        c.add_mode = w[CMD_ADD_BIT];
        c.corr_en  = w[CMD_CORR_BIT];
        c.clr      = w[CMD_CLR_BIT];
        return c;
    endfunction

    // Clear beats any value write; value writes follow the held mode
    function automatic upd_kind_e pick_update(input logic clr,
                                              input logic val_wr,
                                              input logic add_mode);
        if (clr)
            return UPD_CLEAR;
        else if (val_wr)
            return add_mode ? UPD_STEP : UPD_LOAD;
        else
            return UPD_RUN;
    endfunction

endpackage

// File: rtl/ptp_cmd_ctrl.sv
module ptp_cmd_ctrl
    import ptp_tc_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_wdata,
    input  logic             val_wr,
    input  logic [CNT_W-1:0] val_wdata,
    output logic             corr_en,
    output upd_kind_e        upd_kind,
    output logic [CNT_W-1:0] upd_data
);

    cmd_t      cmd_dec;
    logic      cmd_take;
    logic      mode_add_q;
    logic      corr_q;
    upd_kind_e kind_q;
    logic [CNT_W-1:0] data_q;

    assign cmd_dec  = decode_cmd(cmd_wdata);
    assign cmd_take = cmd_wr & cmd_dec.valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_add_q <= 1'b0;
            corr_q     <= 1'b1;
            kind_q     <= UPD_RUN;
            data_q     <= '0;
        end else begin
            if (cmd_take) begin
                mode_add_q <= cmd_dec.add_mode;
                corr_q     <= cmd_dec.corr_en;
            end
            kind_q <= pick_update(cmd_take & cmd_dec.clr, val_wr, mode_add_q);
            if (val_wr)
                data_q <= val_wdata;
        end
    end

    assign corr_en  = corr_q;
    assign upd_kind = kind_q;
    assign upd_data = data_q;

endmodule

// File: rtl/ptp_rate_acc.sv
module ptp_rate_acc #(
    parameter int RATE_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rate_wr,
    input  logic [RATE_W-1:0] rate_wdata,
    input  logic              clr_frac,
    output logic [1:0]        ticks
);

    localparam int FRAC_W = RATE_W - 1;
    localparam logic [RATE_W-1:0] RATE_ONE = {1'b1, {FRAC_W{1'b0}}};

    logic [RATE_W-1:0] rate_q;
    logic [FRAC_W-1:0] frac_q;
    logic [RATE_W:0]   sum;

    assign sum   = {2'b00, frac_q} + {1'b0, rate_q};
    assign ticks = sum[RATE_W:FRAC_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_q <= RATE_ONE;
            frac_q <= '0;
        end else begin
            if (rate_wr)
                rate_q <= rate_wdata;
            frac_q <= clr_frac ? '0 : sum[FRAC_W-1:0];
        end
    end

endmodule

// File: rtl/ptp_time_core.sv
module ptp_time_core
    import ptp_tc_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  upd_kind_e        upd_kind,
    input  logic [CNT_W-1:0] upd_data,
    input  logic [1:0]       ticks,
    output logic [CNT_W-1:0] time_q
);

    logic [CNT_W-1:0] advanced;
    logic [CNT_W-1:0] time_n;

    assign advanced = time_q + CNT_W'(ticks);

    always_comb begin
        unique case (upd_kind)
            UPD_CLEAR: time_n = '0;
            UPD_LOAD:  time_n = upd_data;
            UPD_STEP:  time_n = advanced + upd_data;
            default:   time_n = advanced;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            time_q <= '0;
        else
            time_q <= time_n;
    end

endmodule

// File: rtl/ptp_read_latch.sv
module ptp_read_latch #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_req,
    input  logic [CNT_W-1:0] time_in,
    output logic [CNT_W-1:0] rd_data
);

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else if (rd_req)
            rd_data <= time_in;
    end

endmodule

// File: rtl/ptp_trim_clock.sv
module ptp_trim_clock
    import ptp_tc_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int RATE_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rate_wr,
    input  logic [RATE_W-1:0] rate_wdata,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd_wdata,
    input  logic              val_wr,
    input  logic [CNT_W-1:0]  val_wdata,
    input  logic              rd_req,
    output logic [CNT_W-1:0]  rd_data,
    output logic [CNT_W-1:0]  time_o,
    output logic              corr_en_o
);

    upd_kind_e        upd_kind;
    logic [CNT_W-1:0] upd_data;
    logic [1:0]       ticks;
    logic             clr_frac;
    logic [CNT_W-1:0] time_q;

    assign clr_frac = (upd_kind == UPD_CLEAR) || (upd_kind == UPD_LOAD);

    ptp_cmd_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd_wr    (cmd_wr),
        .cmd_wdata (cmd_wdata),
        .val_wr    (val_wr),
        .val_wdata (val_wdata),
        .corr_en   (corr_en_o),
        .upd_kind  (upd_kind),
        .upd_data  (upd_data)
    );

    ptp_rate_acc #(.RATE_W(RATE_W)) u_rate (
        .clk        (clk),
        .rst        (rst),
        .rate_wr    (rate_wr),
        .rate_wdata (rate_wdata),
        .clr_frac   (clr_frac),
        .ticks      (ticks)
    );

    ptp_time_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .upd_kind (upd_kind),
        .upd_data (upd_data),
        .ticks    (ticks),
        .time_q   (time_q)
    );

    ptp_read_latch #(.CNT_W(CNT_W)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .rd_req  (rd_req),
        .time_in (time_q),
        .rd_data (rd_data)
    );

    assign time_o = time_q;

endmodule

// File: rtl/ptp_trim_clock_chk.sv
module ptp_trim_clock_chk
    import ptp_tc_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_wr,
    input logic [CMD_W-1:0] cmd_wdata,
    input logic             val_wr,
    input logic             rd_req,
    input logic [CNT_W-1:0] rd_data,
    input logic [CNT_W-1:0] time_o,
    input logic             corr_en_o
);

    logic       clr_req;
    logic [1:0] age;

    assign clr_req = cmd_wr && cmd_wdata[CMD_VALID_BIT] && cmd_wdata[CMD_CLR_BIT];

    always_ff @(posedge clk) begin
        if (rst)
            age <= 2'd0;
        else if (age != 2'd3)
            age <= age + 2'd1;
    end

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (time_o == '0) && (rd_data == '0) && corr_en_o);

    // R2 and R3: free running never moves by more than two counts per edge
    assert_step_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && !$past(val_wr, 2) && !$past(clr_req, 2))
        |-> ((time_o - $past(time_o)) <= CNT_W'(2)));

    assert_invalid_cmd_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !cmd_wdata[CMD_VALID_BIT]) |=> $stable(corr_en_o));

    assert_clear_lands_R9: assert property (@(posedge clk) disable iff (rst)
        clr_req |-> ##2 (time_o == '0));

    assert_corr_follow_R10: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && cmd_wdata[CMD_VALID_BIT]) |=> (corr_en_o == $past(cmd_wdata[CMD_CORR_BIT])));

    assert_read_capture_R11: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> (rd_data == $past(time_o)));

    assert_read_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> $stable(rd_data));

endmodule

bind ptp_trim_clock ptp_trim_clock_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_wr    (cmd_wr),
    .cmd_wdata (cmd_wdata),
    .val_wr    (val_wr),
    .rd_req    (rd_req),
    .rd_data   (rd_data),
    .time_o    (time_o),
    .corr_en_o (corr_en_o)
);

// File: tb/ptp_trim_clock_tb_top.sv
module ptp_trim_clock_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rate_wr = 1'b0;
    logic [31:0] rate_wdata = '0;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic        val_wr = 1'b0;
    logic [63:0] val_wdata = '0;
    logic        rd_req = 1'b0;
    logic [63:0] rd_data;
    logic [63:0] time_o;
    logic        corr_en_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptp_trim_clock dut_i (
        .clk        (clk),
        .rst        (rst),
        .rate_wr    (rate_wr),
        .rate_wdata (rate_wdata),
        .cmd_wr     (cmd_wr),
        .cmd_wdata  (cmd_wdata),
        .val_wr     (val_wr),
        .val_wdata  (val_wdata),
        .rd_req     (rd_req),
        .rd_data    (rd_data),
        .time_o     (time_o),
        .corr_en_o  (corr_en_o)
    );

    // Cycle model built from the requirements
    logic [63:0] m_cnt, m_pdata, m_rd;
    logic [30:0] m_frac;
    logic [31:0] m_rate;
    logic [32:0] m_sum;
    logic        m_mode, m_corr, m_pv, m_padd, m_prst;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = '0; m_frac = '0; m_rate = 32'h8000_0000;
            m_mode = 1'b0; m_corr = 1'b1;
            m_pv = 1'b0; m_padd = 1'b0; m_prst = 1'b0; m_pdata = '0; m_rd = '0;
        end else begin
            m_sum = {2'b00, m_frac} + {1'b0, m_rate};
            if (rd_req) m_rd = m_cnt;
            if (m_prst) begin
                m_cnt = '0; m_frac = '0;
            end else if (m_pv && !m_padd) begin
                m_cnt = m_pdata; m_frac = '0;
            end else begin
                m_cnt  = m_cnt + 64'(m_sum[32:31]) + (m_pv ? m_pdata : 64'd0);
                m_frac = m_sum[30:0];
            end
            m_prst = cmd_wr && cmd_wdata[31] && cmd_wdata[2];
            m_pv   = val_wr;
            m_padd = m_mode;
            if (val_wr) m_pdata = val_wdata;
            if (cmd_wr && cmd_wdata[31]) begin
                m_mode = cmd_wdata[0];
                m_corr = cmd_wdata[1];
            end
            if (rate_wr) m_rate = rate_wdata;
        end
    end

    task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic write_val(input logic [63:0] v);
        val_wr = 1'b1; val_wdata = v; step(); val_wr = 1'b0;
    endtask

    task automatic write_cmd(input logic [31:0] c);
        cmd_wr = 1'b1; cmd_wdata = c; step(); cmd_wr = 1'b0;
    endtask

    task automatic write_rate(input logic [31:0] r);
        rate_wr = 1'b1; rate_wdata = r; step(); rate_wr = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (WDOG_LIMIT) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [63:0] t;
        void'($urandom(32'd20240611));
        repeat (3) step();
        rst = 1'b0;

        // R1 reset state
        check64("R1 count", time_o, 64'd0);
        check64("R1 read port", rd_data, 64'd0);
        check64("R1 corr enable", {63'd0, corr_en_o}, 64'd1);

        // R2 nominal rate
        t = time_o;
        repeat (10) step();
        check64("R2 nominal ten edges", time_o, t + 64'd10);

        // R4 / R3: 1.5x from a zero fraction
        t = time_o;
        write_rate(32'hC000_0000);
        check64("R4 old rate on write edge", time_o, t + 64'd1);
        repeat (4) step();
        check64("R3 fractional 1.5x", time_o, t + 64'd7);
        write_rate(32'h8000_0000);

        // R7 load mode
        t = time_o;
        write_val(64'h0123_4567_89AB_CDEF);
        check64("R7 not yet applied", time_o, t + 64'd1);
        step();
        check64("R7 loaded", time_o, 64'h0123_4567_89AB_CDEF);
        step();
        check64("R7 resumes", time_o, 64'h0123_4567_89AB_CDF0);

        // R8 add mode, negative offset
        write_cmd(32'h8000_0003);
        t = time_o;
        write_val(64'hFFFF_FFFF_FFFF_FFFB);
        check64("R8 not yet applied", time_o, t + 64'd1);
        step();
        check64("R8 minus five", time_o, t + 64'd2 - 64'd5);

        // R6 mode persists
        t = time_o;
        write_val(64'd100);
        step();
        check64("R6 add persists", time_o, t + 64'd102);

        // R5 command without valid flag
        t = time_o;
        write_cmd(32'h0000_0004);
        check64("R5 no clear", time_o, t + 64'd1);
        check64("R5 corr kept", {63'd0, corr_en_o}, 64'd1);
        t = time_o;
        write_val(64'h10);
        step();
        check64("R5 mode kept add", time_o, t + 64'd2 + 64'h10);

        // R10 correction enable
        write_cmd(32'h8000_0001);
        check64("R10 corr off", {63'd0, corr_en_o}, 64'd0);
        write_cmd(32'h8000_0003);
        check64("R10 corr on", {63'd0, corr_en_o}, 64'd1);

        // R9 clear
        t = time_o;
        write_cmd(32'h8000_0007);
        check64("R9 not yet cleared", time_o, t + 64'd1);
        step();
        check64("R9 cleared", time_o, 64'd0);
        step();
        check64("R9 counts on", time_o, 64'd1);

        // R12 clear beats value write
        val_wr = 1'b1; val_wdata = 64'h999;
        cmd_wr = 1'b1; cmd_wdata = 32'h8000_0007;
        step();
        val_wr = 1'b0; cmd_wr = 1'b0;
        step();
        check64("R12 clear wins", time_o, 64'd0);

        // R11 read capture and hold
        t = time_o;
        rd_req = 1'b1; step(); rd_req = 1'b0;
        check64("R11 capture", rd_data, t);
        repeat (5) step();
        check64("R11 hold", rd_data, t);
        check64("R2 runs during hold", time_o, t + 64'd6);

        // R6 mode in force before the edge decides
        t = time_o;
        val_wr = 1'b1; val_wdata = 64'd50;
        cmd_wr = 1'b1; cmd_wdata = 32'h8000_0002;
        step();
        val_wr = 1'b0; cmd_wr = 1'b0;
        step();
        check64("R6 old mode add", time_o, t + 64'd52);
        write_val(64'd7);
        step();
        check64("R6 new mode load", time_o, 64'd7);

        // Random phase against the model (R3, R8, R10, R11)
        for (int i = 0; i < 400; i++) begin
            int unsigned op;
            int          off;
            op = $urandom % 6;
            case (op)
                0: begin
                    off = int'($urandom % 32'd137438953) - 68719476;
                    rate_wr = 1'b1; rate_wdata = 32'h8000_0000 + 32'(off);
                end
                1: begin
                    val_wr = 1'b1; val_wdata = {$urandom, $urandom};
                end
                2: begin
                    cmd_wr = 1'b1;
                    cmd_wdata = {1'($urandom % 2), 28'd0, 1'(($urandom % 8) == 0), 2'($urandom % 4)};
                end
                3: rd_req = 1'b1;
                4: ;
                default: begin
                    val_wr = 1'b1; val_wdata = 64'($urandom % 1000);
                    rd_req = 1'b1;
                    cmd_wr = 1'b1; cmd_wdata = {1'b1, 29'd0, 2'($urandom % 4)};
                end
            endcase
            step();
            rate_wr = 1'b0; val_wr = 1'b0; cmd_wr = 1'b0; rd_req = 1'b0;
            check64("R3 random count", time_o, m_cnt);
            check64("R11 random read", rd_data, m_rd);
            check64("R10 random corr", {63'd0, corr_en_o}, {63'd0, m_corr});
        end

        done = 1'b1;
        finish_run();
    end

endmodule